// File: doc/BRIEF.md
# Two-Row-Buffer DRAM Bank Controller

This block fronts one single-ported DRAM bank that serves one simple processing element. The element issues 32-bit word reads and writes over a valid/ready request channel. The controller keeps two rows of the bank open at once, each in its own row buffer. An access whose row is already held in either buffer finishes after a short fixed latency. Any other access refills one buffer from the array and finishes after a longer fixed latency. The array itself is modelled behaviourally inside the block.

Only one request is in flight at a time. `req_ready` drops once a request is taken and rises again when that request completes. A read returns its word with a one-cycle `rsp_valid` pulse. Writes that hit change only the buffer. A modified buffer is copied back to the array before it is reused, and that copy lengthens the miss. On a miss, the buffer used least recently is the one refilled.

The full 1 MB bank corresponds to `COL_W = 11` and `ROW_W = 9`. The default `ROW_W` is small so that the behavioural array stays compact when the block is built with its default parameters.

Top module: `dual_rowbuf_bank`

## Requirements
- R1: Only one request is in progress at a time. `req_ready` is low from the cycle after a request is accepted until that request completes, and is high again in the cycle in which the completion becomes visible.
- R2: Each of the two buffers holds one whole row, and no row is held by both buffers. Once two rows are loaded, accesses that alternate between them all hit.
- R3: A request that hits either buffer completes HIT_LAT (default 4) clock edges after the edge that accepted it. For a read, `rsp_valid` is first high after that edge.
- R4: A request that misses both buffers, where the buffer being replaced is empty or unmodified, completes MISS_LAT (default 8) edges after acceptance.
- R5: A miss that replaces a modified buffer completes MISS_LAT + WB_LAT (default 12) edges after acceptance.
- R6: `req_addr` is a byte address. Bits [COL_W-1:2] select the 32-bit word within a row, bits above COL_W-1 select the row, and bits [1:0] are ignored.
- R7: On a miss, the buffer refilled is the one not used by the most recent access. After reset, buffer 0 is filled first.
- R8: A read returns the most recent value written to that word, whether that value still sits in a modified buffer or was copied back to the array and later reloaded.
- R9: `rsp_valid` is a single-cycle pulse raised only when a read completes. A completing write raises no `rsp_valid`.
- R10: After reset, `req_ready` is high, `rsp_valid` is low and both buffers are empty, so the first access is a miss.
- R11: Words are 32 bits wide, and all bits are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Byte address within the bank |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The bench builds the block with `ROW_W = 3` and `COL_W = 4`, which gives eight rows of four words each, and keeps the default latencies of 4, 8 and 12 cycles. With rows this short, a handful of requests is enough to fill both buffers, evict a modified row, reload it and compare its data. Replacement order, write-back timing and all three latency classes therefore appear many times within a short run. A reference model inside the bench tracks its own copy of the buffers and their recency, and from that copy it predicts both the latency and the returned data of every request.

// File: rtl/drb_pkg.sv
package drb_pkg;

  typedef enum logic [1:0] {
    KIND_HIT     = 2'd0,
    KIND_MISS    = 2'd1,
    KIND_MISS_WB = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic hit, input logic victim_dirty);
    if (hit)               return KIND_HIT;
    else if (victim_dirty) return KIND_MISS_WB;
    else                   return KIND_MISS;
  endfunction

  function automatic int unsigned access_cycles(input acc_kind_e kind,
                                                input int unsigned hit_lat,
                                                input int unsigned miss_lat,
                                                input int unsigned wb_lat);
    case (kind)
      KIND_HIT:     return hit_lat;
      KIND_MISS_WB: return miss_lat + wb_lat;
      default:      return miss_lat;
    endcase
  endfunction

endpackage

// File: rtl/drb_timer.sv
module drb_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= load - CNT_W'(1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/drb_tags.sv
module drb_tags #(
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] look_row,
  output logic [1:0]       hit_vec,
  output logic             hit,
  output logic             hit_way,
  output logic             victim_way,
  output logic             victim_dirty,
  output logic [ROW_W-1:0] victim_row,
  input  logic             upd,
  input  logic             upd_way,
  input  logic             upd_miss,
  input  logic             upd_write,
  input  logic [ROW_W-1:0] upd_row
);
  logic [ROW_W-1:0] tag_q   [2];
  logic [1:0]       valid_q;
  logic [1:0]       dirty_q;
  logic             lru_q;

  for (genvar g = 0; g < 2; g++) begin : g_way
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_row);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g]   <= '0;
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (upd && (upd_way == 1'(g))) begin
        if (upd_miss) begin
          tag_q[g]   <= upd_row;
          valid_q[g] <= 1'b1;
          dirty_q[g] <= upd_write;
        end else if (upd_write) begin
          dirty_q[g] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   lru_q <= 1'b0;
    else if (upd) lru_q <= ~upd_way;
  end

  assign hit          = |hit_vec;
  assign hit_way      = hit_vec[1];
  assign victim_way   = lru_q;
  assign victim_dirty = valid_q[lru_q] && dirty_q[lru_q];
  assign victim_row   = tag_q[lru_q];
endmodule

// File: rtl/drb_store.sv
module drb_store #(
  parameter int ROW_W  = 2,
  parameter int WORD_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              fire,
  input  logic              miss,
  input  logic              way,
  input  logic              wb,
  input  logic [ROW_W-1:0]  wb_row,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] word,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;
  localparam int WPR  = 1 << WORD_W;

  logic [DATA_W-1:0] arr  [ROWS][WPR];
  logic [DATA_W-1:0] rbuf [2][WPR];

  always_ff @(posedge clk) begin
    if (fire) begin
      if (miss) begin
        if (wb) begin
          for (int w = 0; w < WPR; w++) arr[wb_row][w] <= rbuf[way][w];
        end
        for (int w = 0; w < WPR; w++) rbuf[way][w] <= arr[row][w];
        if (write) rbuf[way][word] <= wdata;
        rdata <= arr[row][word];
      end else begin
        if (write) rbuf[way][word] <= wdata;
        rdata <= rbuf[way][word];
      end
    end
  end
endmodule

// File: rtl/dual_rowbuf_bank.sv
module dual_rowbuf_bank #(
  parameter int ROW_W    = 2,
  parameter int COL_W    = 11,
  parameter int DATA_W   = 32,
  parameter int HIT_LAT  = 4,
  parameter int MISS_LAT = 8,
  parameter int WB_LAT   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata
);
  import drb_pkg::*;

  localparam int ADDR_W   = ROW_W + COL_W;
  localparam int BYTE_OFS = $clog2(DATA_W / 8);
  localparam int WORD_W   = COL_W - BYTE_OFS;
  localparam int CNT_W    = $clog2(HIT_LAT + MISS_LAT + WB_LAT + 1);

  // named events
  logic              accept;
  logic              tm_busy;
  logic              tm_done;
  logic [CNT_W-1:0]  lat_load;
  logic [ROW_W-1:0]  req_row;
  logic [WORD_W-1:0] req_word;
  logic              unused_lo;

  logic [1:0]        lk_hit_vec;
  logic              lk_hit;
  logic              lk_hit_way;
  logic              lk_victim;
  logic              lk_victim_dirty;
  logic [ROW_W-1:0]  lk_victim_row;

  // captured request
  logic [ROW_W-1:0]  row_q;
  logic [ROW_W-1:0]  wbrow_q;
  logic [WORD_W-1:0] word_q;
  logic [DATA_W-1:0] wdata_q;
  logic              write_q;
  logic              miss_q;
  logic              way_q;
  logic              wb_q;

  assign req_row   = req_addr[ADDR_W-1:COL_W];
  assign req_word  = req_addr[COL_W-1:BYTE_OFS];
  assign unused_lo = &{1'b0, req_addr[BYTE_OFS-1:0]};
  assign req_ready = !tm_busy;
  assign accept    = req_valid && req_ready;
  assign lat_load  = CNT_W'(access_cycles(classify(lk_hit, lk_victim_dirty),
                                          HIT_LAT, MISS_LAT, WB_LAT));

  drb_tags #(.ROW_W(ROW_W)) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .look_row     (req_row),
    .hit_vec      (lk_hit_vec),
    .hit          (lk_hit),
    .hit_way      (lk_hit_way),
    .victim_way   (lk_victim),
    .victim_dirty (lk_victim_dirty),
    .victim_row   (lk_victim_row),
    .upd          (tm_done),
    .upd_way      (way_q),
    .upd_miss     (miss_q),
    .upd_write    (write_q),
    .upd_row      (row_q)
  );

  drb_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .load  (lat_load),
    .busy  (tm_busy),
    .done  (tm_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      wbrow_q <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      miss_q  <= 1'b0;
      way_q   <= 1'b0;
      wb_q    <= 1'b0;
    end else if (accept) begin
      row_q   <= req_row;
      wbrow_q <= lk_victim_row;
      word_q  <= req_word;
      wdata_q <= req_wdata;
      write_q <= req_write;
      miss_q  <= !lk_hit;
      way_q   <= lk_hit ? lk_hit_way : lk_victim;
      wb_q    <= !lk_hit && lk_victim_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= tm_done && !write_q;
  end

  drb_store #(.ROW_W(ROW_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_store (
    .clk    (clk),
    .fire   (tm_done),
    .miss   (miss_q),
    .way    (way_q),
    .wb     (wb_q),
    .wb_row (wbrow_q),
    .row    (row_q),
    .word   (word_q),
    .write  (write_q),
    .wdata  (wdata_q),
    .rdata  (rsp_rdata)
  );
endmodule

// File: rtl/drb_checker.sv
module drb_checker #(
  parameter int HIT_LAT  = 4,
  parameter int MISS_LAT = 8,
  parameter int WB_LAT   = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       accept,
  input logic       busy,
  input logic       done,
  input logic       lk_hit,
  input logic       lk_victim_dirty,
  input logic [1:0] lk_hit_vec
);
  int unsigned lat_cnt;
  int unsigned lat_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= 0;
      lat_exp <= 0;
    end else if (accept) begin
      lat_cnt <= 1;
      if (lk_hit)               lat_exp <= HIT_LAT;
      else if (lk_victim_dirty) lat_exp <= MISS_LAT + WB_LAT;
      else                      lat_exp <= MISS_LAT;
    end else if (busy) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready); // R1
  AST_READY_AFTER_DONE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> req_ready); // R1
  AST_ROW_UNIQUE:        assert property (@(posedge clk) disable iff (!rst_n) $countones(lk_hit_vec) <= 1); // R2
  AST_LATENCY_EXACT:     assert property (@(posedge clk) disable iff (!rst_n) done |-> lat_cnt == lat_exp); // R3
  AST_RSP_PULSE:         assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R9
  AST_RSP_FROM_DONE:     assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(done)); // R9
endmodule

bind dual_rowbuf_bank drb_checker #(
  .HIT_LAT  (HIT_LAT),
  .MISS_LAT (MISS_LAT),
  .WB_LAT   (WB_LAT)
) u_drb_checker (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_ready       (req_ready),
  .rsp_valid       (rsp_valid),
  .accept          (accept),
  .busy            (tm_busy),
  .done            (tm_done),
  .lk_hit          (lk_hit),
  .lk_victim_dirty (lk_victim_dirty),
  .lk_hit_vec      (lk_hit_vec)
);

// File: tb/test_dual_rowbuf_bank.sv
module test_dual_rowbuf_bank;
  localparam int ROW_W = 3;
  localparam int COL_W = 4;
  localparam int HIT   = 4;
  localparam int MISS  = 8;
  localparam int WB    = 4;
  localparam int AW    = ROW_W + COL_W;
  localparam int WPR   = 1 << (COL_W - 2);
  localparam int NW    = (1 << ROW_W) * WPR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;

  always #10 clk = ~clk;

  dual_rowbuf_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(32),
                     .HIT_LAT(HIT), .MISS_LAT(MISS), .WB_LAT(WB)) i_dual_rowbuf_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int checks = 0;
  int fails = 0;
  int unsigned cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit          wr;
    logic [31:0] data;
    bit          known;
    int unsigned acc;
    int unsigned lat;
    string       req;
  } item_t;
  item_t sb[$];

  // reference model
  int          m_tag [2];
  bit          m_val [2];
  bit          m_dirty [2];
  bit          m_lru = 1'b0;
  logic [31:0] mem [NW];
  bit          kn [NW];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic op(input bit wr, input int row, input int word, input int low,
                    input logic [31:0] d, input string req);
    item_t it;
    int hw;
    int way;
    int idx;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    hw = -1;
    for (int w = 0; w < 2; w++) if (m_val[w] && m_tag[w] == row) hw = w;
    if (hw >= 0) begin
      way = hw;
      it.lat = HIT;
      if (wr) m_dirty[way] = 1'b1;
    end else begin
      way = int'(m_lru);
      it.lat = (m_val[way] && m_dirty[way]) ? MISS + WB : MISS;
      m_tag[way] = row;
      m_val[way] = 1'b1;
      m_dirty[way] = wr;
    end
    m_lru = (way == 0);
    idx = row * WPR + word;
    it.wr = wr;
    it.data = mem[idx];
    it.known = kn[idx];
    if (wr) begin
      mem[idx] = d;
      kn[idx] = 1'b1;
    end
    it.acc = cyc + 1;
    it.req = req;
    sb.push_back(it);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'((row << COL_W) | (word << 2) | low);
    req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  bit prev_rdy = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!prev_rdy && req_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1", "completion with empty scoreboard", 1, 0);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(cyc - it.acc == it.lat, it.req, "latency", cyc - it.acc, it.lat);
          check(rsp_valid == !it.wr, "R9", "rsp_valid at completion", rsp_valid, !it.wr);
          if (!it.wr && it.known)
            check(rsp_rdata == it.data, it.req, "read data (R8)", rsp_rdata, it.data);
        end
      end else if (rsp_valid) begin
        check(1'b0, "R9", "spurious rsp_valid", 1, 0);
      end
    end
    prev_rdy = req_ready;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) kn[i] = 1'b0;
    for (int w = 0; w < 2; w++) begin
      m_val[w] = 1'b0; m_dirty[w] = 1'b0; m_tag[w] = 0;
    end
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready during reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
    check(rsp_valid == 1'b0, "R10", "rsp_valid after reset", rsp_valid, 0);

    op(1, 0, 1, 0, 32'hFFFF_0001, "R10");   // first access misses (R4)
    op(0, 0, 1, 0, 0, "R3");                // hit, R11 full word
    op(0, 0, 1, 3, 0, "R6");                // low bits ignored
    op(1, 1, 0, 0, 32'h8000_00B0, "R4");    // clean miss into buffer 1
    op(0, 0, 1, 0, 0, "R2");
    op(0, 1, 0, 0, 0, "R2");
    op(1, 2, 3, 0, 32'h1234_ABCD, "R5");    // evicts dirty row 0
    op(0, 1, 0, 2, 0, "R7");                // row 1 kept
    op(0, 0, 1, 0, 0, "R8");                // reload written-back row
    op(0, 2, 3, 0, 0, "R8");
    op(0, 1, 0, 0, 0, "R8");
    op(1, 1, 2, 0, 32'h0F0F_F0F0, "R11");
    op(0, 1, 2, 1, 0, "R11");

    for (int i = 0; i < 48; i++) begin
      op((i % 3) == 0, (i * 5 + 3) % (1 << ROW_W), (i * 3) % WPR, i % 4,
         32'hC0DE_0000 ^ (i * 32'h0101_0101), "R7");
    end
    for (int r = 0; r < (1 << ROW_W); r++)
      for (int w = 0; w < WPR; w++) op(0, r, w, 0, 0, "R8");

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R9", "idle at end",
          {rsp_valid, req_ready}, 2'b01);
    finish_run();
  end
endmodule